// File: doc/BRIEF.md
# Change-of-State Input Detector

This block watches a small group of general-purpose input pins and reports which of them have changed level since the host last looked. Each pin passes through a synchroniser. A free-running prescaler then samples the group once every `PRESCALE` clock cycles. Any bit whose sampled value differs from the previous sample sets a sticky change flag for that input.

The host sees the block through one read strobe and a one-bit select. With select 0 the read port returns the most recent sampled levels. With select 1 it returns the change flags. A flag read is in progress for as long as the strobe is held with select 1. During that time the flag register is frozen. Any change detected while it is frozen is held in a pending register. On the first cycle after the read ends, the reported flags are cleared and the pending changes are loaded in their place. No edge is lost at the read boundary.

An interrupt output is high while any flag is set whose bit is also set in the per-input enable mask.

Top module: `cos_detector`

## Requirements
- R1: After reset, the level view and the flag view both read all zeros, and `irq_o` is low.
- R2: Inputs are sampled on one clock edge in every `PRESCALE` cycles. The first sample is taken `PRESCALE` cycles after reset is released. Successive samples are exactly `PRESCALE` cycles apart.
- R3: The first sample after reset only loads the previous-sample register. It sets no change flag, whatever the input levels are.
- R4: Bit i of the flag view (`rd_sel_i` = 1) is set when the sampled level of input i differs from its previous sample. The bit stays set when the input later returns to its old level, until a flag read clears it.
- R5: Bit i of the level view (`rd_sel_i` = 0) is the last sampled level of input i. A read with `rd_sel_i` = 0 leaves the flags unchanged.
- R6: While `rd_en_i` = 1 and `rd_sel_i` = 1 (a flag read), the flag register holds its value. On the first clock edge after the read ends, every reported flag is cleared.
- R7: A change sampled during a flag read is not shown in that read. It is set in the flag register on the edge at which the read ends.
- R8: `irq_o` is high exactly while (flags AND `irq_mask_i`) is nonzero. A flag whose mask bit is 0 does not raise it.
- R9: Each input passes through a two-flop synchroniser. A pin change made just after one sample is captured by the next sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_IN | Asynchronous monitored inputs |
| rd_en_i | input | 1 | Read strobe, held high for the duration of a read |
| rd_sel_i | input | 1 | Read select: 0 selects levels, 1 selects change flags |
| rd_data_o | output | NUM_IN | Read data for the selected view (combinational) |
| irq_mask_i | input | NUM_IN | Per-input interrupt enable |
| irq_o | output | 1 | Interrupt, high while any enabled flag is set |

## Verification
The most important corner is a change that is sampled while a long flag read spans a sample edge. A design without the interlock would either show the new bit inside the frozen read or clear it at the end of the read, and that edge would be lost. The bench measures the interval between two sample edges exactly. A prescaler that is off by one would give the wrong count. The bench also checks three more cases: an input that returns to its old level must stay flagged, a level read must not clear the flags, and inputs that are already high before reset must not produce flags on the priming sample.

// File: rtl/cos_pkg.sv
package cos_pkg;
    typedef enum logic {
        SEL_LEVEL = 1'b0,
        SEL_FLAGS = 1'b1
    } cos_sel_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];

    // R9
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stage_q[0] == $past(din));
endmodule

// File: rtl/cos_prescaler.sv
module cos_prescaler #(
    parameter int PRESCALE = 92
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    generate
        if (PRESCALE > 1) begin : g_gap
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/cos_flag_bank.sv
module cos_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] sample_i,
    input  logic         flag_rd_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0] level;
        logic [W-1:0] flags;
        logic [W-1:0] pending;
        logic         primed;
        logic         rd_act;
    } bank_t;

    bank_t        s_d, s_q;
    logic [W-1:0] chg;
    logic         rd_end;

    always_comb begin
        s_d    = s_q;
        chg    = '0;
        rd_end = s_q.rd_act && !flag_rd_i;
        if (tick_i) begin
            s_d.level = sample_i;
            if (s_q.primed) chg = sample_i ^ s_q.level;
            else            s_d.primed = 1'b1;
        end
        s_d.rd_act = flag_rd_i;
        if (flag_rd_i) begin
            s_d.pending = s_q.pending | chg;
        end else if (rd_end) begin
            s_d.flags   = s_q.pending | chg;
            s_d.pending = '0;
        end else begin
            s_d.flags   = s_q.flags | chg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.level;
    assign flags_o = s_q.flags;

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd_i |=> $stable(s_q.flags));

    // R7
    pending_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.rd_act |-> s_q.pending == '0);

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_end |=> ((s_q.flags & $past(s_q.flags)) == $past(s_q.flags)));

    // R3
    no_prime_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.primed |-> s_q.flags == '0);
endmodule

// File: rtl/cos_detector.sv
module cos_detector #(
    parameter int NUM_IN      = 4,
    parameter int PRESCALE    = 92,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] pin_i,
    input  logic              rd_en_i,
    input  logic              rd_sel_i,
    output logic [NUM_IN-1:0] rd_data_o,
    input  logic [NUM_IN-1:0] irq_mask_i,
    output logic              irq_o
);
    import cos_pkg::*;

    logic [NUM_IN-1:0] synced, level, flags;
    logic              tick, flag_rd;

    cos_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_i), .dout(synced));

    cos_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick));

    cos_flag_bank #(.W(NUM_IN)) u_bank (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .sample_i(synced),
        .flag_rd_i(flag_rd), .level_o(level), .flags_o(flags));

    always_comb begin
        flag_rd   = rd_en_i && (cos_sel_e'(rd_sel_i) == SEL_FLAGS);
        rd_data_o = (cos_sel_e'(rd_sel_i) == SEL_FLAGS) ? flags : level;
        irq_o     = |(flags & irq_mask_i);
    end
endmodule

// File: tb/cos_detector_bench.sv
module cos_detector_bench;
    localparam int N = 4;
    localparam int P = 92;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = 4'b1010;
    logic         rd_en = 1'b0;
    logic         rd_sel = 1'b0;
    logic [N-1:0] mask = '0;
    logic [N-1:0] rd_data;
    logic         irq;
    int           n_run = 0;
    int           n_fail = 0;

    always #4 clk = ~clk;

    cos_detector #(.NUM_IN(N), .PRESCALE(P), .SYNC_STAGES(2)) u_cos_detector (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .rd_en_i(rd_en),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_mask_i(mask),
        .irq_o(irq));

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic sel, output logic [N-1:0] v);
        @(negedge clk);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_prime();
        logic [N-1:0] v;
        #1;
        rd_sel = 1'b0; #1 check("R1 level at reset", rd_data, 0);
        rd_sel = 1'b1; #1 check("R1 flags at reset", rd_data, 0);
        check("R1 irq at reset", irq, 0);
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(P + 4);
        peek(1'b0, v); check("R5 level after prime", v, 4'b1010);
        peek(1'b1, v); check("R3 no flag on prime", v, 0);
    endtask

    task automatic t_period();
        logic [N-1:0] v;
        int c1, c2;
        c1 = 0; c2 = 0;
        @(negedge clk); pin[0] = 1'b1;
        do begin peek(1'b0, v); c1++; end while (v[0] != 1'b1 && c1 < 3 * P);
        check("R9 first capture latency bound", (c1 <= P + 2), 1);
        pin[0] = 1'b0;
        do begin peek(1'b0, v); c2++; end while (v[0] != 1'b0 && c2 < 3 * P);
        check("R2 sample interval", c2, P);
        peek(1'b1, v); check("R4 flag after toggle-back", v, 4'b0001);
    endtask

    task automatic t_sticky_level_read();
        logic [N-1:0] v;
        @(negedge clk); pin[2] = 1'b1;
        wait_cyc(2 * P);
        peek(1'b1, v); check("R4 second flag", v, 4'b0101);
        @(negedge clk); rd_sel = 1'b0; rd_en = 1'b1;
        wait_cyc(3);
        rd_en = 1'b0;
        peek(1'b0, v); check("R5 level view", v, 4'b1110);
        peek(1'b1, v); check("R5 level read keeps flags", v, 4'b0101);
    endtask

    task automatic t_irq();
        @(negedge clk); mask = 4'b0000; #1 check("R8 irq masked off", irq, 0);
        @(negedge clk); mask = 4'b1010; #1 check("R8 irq unflagged bits", irq, 0);
        @(negedge clk); mask = 4'b0100; #1 check("R8 irq enabled flag", irq, 1);
        @(negedge clk); mask = 4'b0000;
    endtask

    task automatic t_flag_read();
        logic [N-1:0] v;
        @(negedge clk); rd_sel = 1'b1; rd_en = 1'b1;
        #1 check("R6 read data", rd_data, 4'b0101);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1 check("R6 frozen during read", rd_data, 4'b0101);
        end
        @(negedge clk); rd_en = 1'b0;
        peek(1'b1, v); check("R6 cleared after read", v, 0);
        mask = 4'b1111; #1 check("R6 irq low after clear", irq, 0);
    endtask

    task automatic t_pending();
        logic [N-1:0] v;
        @(negedge clk); pin[3] = 1'b0;
        wait_cyc(2 * P);
        peek(1'b1, v); check("R4 setup flag bit3", v, 4'b1000);
        @(negedge clk); rd_sel = 1'b1; rd_en = 1'b1; pin[1] = 1'b0;
        wait_cyc(P + 6);
        #1 check("R7 change hidden in read", rd_data, 4'b1000);
        @(negedge clk); rd_en = 1'b0;
        peek(1'b1, v); check("R7 pending loaded at end", v, 4'b0010);
        mask = 4'b0010; #1 check("R8 irq from pending bit", irq, 1);
        peek(1'b0, v); check("R5 level after pending", v, 4'b0100);
    endtask

    initial begin
        t_reset_prime();
        t_period();
        t_sticky_level_read();
        t_irq();
        t_flag_read();
        t_pending();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule